// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). In every cycle it compares each source register of the instruction in decode with the destination registers of the three instructions further down the pipe. For each source operand it produces a two-bit select. The select tells the operand mux whether to use the register file or a result that has been computed but not yet written back. Bypassing is needed because the register file is written too late for the consumers that follow closely behind a producer.

When the closest producer of an operand is a load that is still in execute, the data does not exist yet. The unit then raises a hold, which freezes the fetch and decode registers, and a bubble, which replaces the instruction entering execute with a no-op. One cycle later the load has moved to the memory stage. Its data is then bypassed from the memory/writeback boundary and the hold drops. The unit is purely combinational and compares register numbers only. Branch hazards are handled elsewhere.

Top module: `fwd_stall_ctrl`

## Requirements
- R1: An operand with no matching in-flight writer gets select 0 (register file).
- R2: An operand whose register matches the execute-stage destination, with write enable set, gets select 1 (execute result).
- R3: An operand whose closest match is the memory stage gets select 2 (memory result). This includes a load that has advanced there after a stall.
- R4: An operand whose only match is the writeback stage gets select 3 (writeback value).
- R5: When several stages write the operand's register, the youngest one has priority: execute over memory, and memory over writeback.
- R6: A stage whose write enable is 0 is never a bypass source and never causes a stall.
- R7: Register 0 is never bypassed (select 0) and never causes a stall, even when every stage targets register 0.
- R8: If any operand's closest producer is a load in execute (load flag and write enable set, register not 0), then hold_o and bubble_o are both 1.
- R9: hold_o and bubble_o are 0 when no operand depends on a load in execute. This covers a non-load producer in execute, a load writing another register, and a load in the memory or writeback stage.
- R10: Each operand is resolved on its own. One operand can be bypassed while the other causes a stall, and a stall on either operand raises the controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_rs_i | input | NUM_SRC*REG_W | Source register numbers of the decode instruction; operand s is in slice s |
| ex_rd_i | input | REG_W | Destination register of the execute-stage instruction |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_rd_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | REG_W | Destination register of the writeback-stage instruction |
| wb_we_i | input | 1 | Writeback-stage instruction writes a register |
| byp_sel_o | output | NUM_SRC*2 | Per-operand select: 0 register file, 1 execute, 2 memory, 3 writeback |
| hold_o | output | 1 | Freeze the fetch and decode registers |
| bubble_o | output | 1 | Insert a no-op into execute |

## Verification
Bypassing and the load-use stall can both apply in the same cycle. They can meet on one operand, when a load in execute and an older writer in memory target the same register. They can also split across the two operands, one bypassed from memory and the other waiting on the load. Directed vectors set up both cases. Random vectors over a register range of only four values produce many more of them. For each vector the bench computes the expected select per operand and the expected hold and bubble from the priority rules, and then compares all of them. The sequence in which a stalled load advances to the memory stage is also driven, and the bench checks that the hold is released and the select switches to the memory result.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'd0,
    BYP_EX  = 2'd1,
    BYP_MEM = 2'd2,
    BYP_WB  = 2'd3
  } byp_sel_e;

  // producer order: index 0 youngest (execute) .. NUM_PROD-1 oldest (writeback)
  localparam int unsigned NUM_PROD = 3;
  localparam int unsigned SEL_W    = 2;
endpackage

// File: rtl/fwd_src_match.sv
module fwd_src_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] rs_i,
  input  logic [REG_W-1:0] rd_i,
  input  logic             we_i,
  output logic             hit_o
);
  assign hit_o = we_i && (rd_i == rs_i) && (rs_i != '0);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0]          rs_i,
  input  logic [NUM_PROD*REG_W-1:0] prod_rd_i,
  input  logic [NUM_PROD-1:0]       prod_we_i,
  input  logic                      ex_load_i,
  output byp_sel_e                  sel_o,
  output logic                      load_use_o
);
  logic [NUM_PROD-1:0] hit;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    fwd_src_match #(.REG_W(REG_W)) i_match (
      .rs_i  (rs_i),
      .rd_i  (prod_rd_i[p*REG_W +: REG_W]),
      .we_i  (prod_we_i[p]),
      .hit_o (hit[p])
    );
  end

  // oldest first so the youngest hit overrides
  always_comb begin
    sel_o = BYP_RF;
    for (int p = NUM_PROD - 1; p >= 0; p--) begin
      if (hit[p]) sel_o = byp_sel_e'(SEL_W'(p + 1));
    end
  end

  assign load_use_o = hit[0] && ex_load_i;
endmodule

// File: rtl/fwd_stall_ctrl.sv
module fwd_stall_ctrl
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic [NUM_SRC*REG_W-1:0] dec_rs_i,
  input  logic [REG_W-1:0]         ex_rd_i,
  input  logic                     ex_we_i,
  input  logic                     ex_load_i,
  input  logic [REG_W-1:0]         mem_rd_i,
  input  logic                     mem_we_i,
  input  logic [REG_W-1:0]         wb_rd_i,
  input  logic                     wb_we_i,
  output logic [NUM_SRC*SEL_W-1:0] byp_sel_o,
  output logic                     hold_o,
  output logic                     bubble_o
);
  logic [NUM_PROD*REG_W-1:0] prod_rd;
  logic [NUM_PROD-1:0]       prod_we;
  logic [NUM_SRC-1:0]        load_use;

  assign prod_rd = {wb_rd_i, mem_rd_i, ex_rd_i};
  assign prod_we = {wb_we_i, mem_we_i, ex_we_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    byp_sel_e sel;
    fwd_operand_sel #(.REG_W(REG_W)) i_opsel (
      .rs_i       (dec_rs_i[s*REG_W +: REG_W]),
      .prod_rd_i  (prod_rd),
      .prod_we_i  (prod_we),
      .ex_load_i  (ex_load_i),
      .sel_o      (sel),
      .load_use_o (load_use[s])
    );
    assign byp_sel_o[s*SEL_W +: SEL_W] = sel;
  end

  assign hold_o   = |load_use;
  assign bubble_o = |load_use;
endmodule

// File: rtl/fwd_stall_chk.sv
module fwd_stall_chk #(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned NUM_SRC = 2
) (
  input logic [NUM_SRC*REG_W-1:0] dec_rs_i,
  input logic [REG_W-1:0]         ex_rd_i,
  input logic                     ex_we_i,
  input logic                     ex_load_i,
  input logic [REG_W-1:0]         mem_rd_i,
  input logic                     mem_we_i,
  input logic [REG_W-1:0]         wb_rd_i,
  input logic                     wb_we_i,
  input logic [NUM_SRC*2-1:0]     byp_sel_o,
  input logic                     hold_o,
  input logic                     bubble_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [REG_W-1:0] rs;
    logic [1:0]       sel;
    assign rs  = dec_rs_i[s*REG_W +: REG_W];
    assign sel = byp_sel_o[s*2 +: 2];

    always_comb begin
      AST_ZERO_REG_RF: assert (rs != '0 || sel == 2'd0); // R7
      AST_EX_SRC_OK: assert (sel != 2'd1 || (ex_we_i && ex_rd_i == rs)); // R2
      AST_MEM_YOUNGEST: assert (sel != 2'd2 || (mem_we_i && mem_rd_i == rs && !(ex_we_i && ex_rd_i == rs))); // R5
      AST_WB_YOUNGEST: assert (sel != 2'd3 || (wb_we_i && wb_rd_i == rs && !(mem_we_i && mem_rd_i == rs))); // R4
      AST_LOAD_USE_HOLD: assert (!(ex_load_i && sel == 2'd1) || (hold_o && bubble_o)); // R8
    end
  end

  always_comb begin
    AST_HOLD_CAUSE: assert (!hold_o || (ex_load_i && ex_we_i && ex_rd_i != '0)); // R9
    AST_BUBBLE_CAUSE: assert (!bubble_o || (ex_load_i && ex_we_i && ex_rd_i != '0)); // R9
  end
endmodule

bind fwd_stall_ctrl fwd_stall_chk #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_fwd_stall_chk (
  .dec_rs_i  (dec_rs_i),
  .ex_rd_i   (ex_rd_i),
  .ex_we_i   (ex_we_i),
  .ex_load_i (ex_load_i),
  .mem_rd_i  (mem_rd_i),
  .mem_we_i  (mem_we_i),
  .wb_rd_i   (wb_rd_i),
  .wb_we_i   (wb_we_i),
  .byp_sel_o (byp_sel_o),
  .hold_o    (hold_o),
  .bubble_o  (bubble_o)
);

// File: tb/test_fwd_stall_ctrl.sv
module test_fwd_stall_ctrl;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned NUM_SRC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [REG_W-1:0] rs0, rs1, ex_rd, mem_rd, wb_rd;
  logic ex_we, ex_ld, mem_we, wb_we;
  logic [NUM_SRC*2-1:0] sel;
  logic hold, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  fwd_stall_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_fwd_stall_ctrl (
    .dec_rs_i  ({rs1, rs0}),
    .ex_rd_i   (ex_rd),
    .ex_we_i   (ex_we),
    .ex_load_i (ex_ld),
    .mem_rd_i  (mem_rd),
    .mem_we_i  (mem_we),
    .wb_rd_i   (wb_rd),
    .wb_we_i   (wb_we),
    .byp_sel_o (sel),
    .hold_o    (hold),
    .bubble_o  (bubble)
  );

  function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] rs);
    if (rs == '0) return 2'd0;
    if (ex_we && ex_rd == rs) return 2'd1;
    if (mem_we && mem_rd == rs) return 2'd2;
    if (wb_we && wb_rd == rs) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic exp_stall();
    return (exp_sel(rs0) == 2'd1 || exp_sel(rs1) == 2'd1) && ex_ld;
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    cmp(req, "sel0", int'(sel[1:0]), int'(exp_sel(rs0)));
    cmp(req, "sel1", int'(sel[3:2]), int'(exp_sel(rs1)));
    cmp(req, "hold", int'(hold), int'(exp_stall()));
    cmp(req, "bubble", int'(bubble), int'(exp_stall()));
  endtask

  task automatic drive(input int r0, input int r1, input int erd, input bit ewe, input bit eld,
                       input int mrd, input bit mwe, input int wrd, input bit wwe);
    @(negedge clk);
    rs0 = REG_W'(r0); rs1 = REG_W'(r1);
    ex_rd = REG_W'(erd); ex_we = ewe; ex_ld = eld;
    mem_rd = REG_W'(mrd); mem_we = mwe;
    wb_rd = REG_W'(wrd); wb_we = wwe;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // reset state: idle pipe gives register file and no stall
    cmp("R1", "reset sel", int'(sel), 0);
    cmp("R9", "reset hold", int'(hold), 0);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    drive(3, 4, 5, 1, 0, 6, 1, 7, 1);  check_all("R1");
    drive(5, 4, 5, 1, 0, 6, 1, 7, 1);
    cmp("R2", "ex sel0", int'(sel[1:0]), 1); check_all("R2");
    drive(3, 6, 5, 1, 0, 6, 1, 7, 1);
    cmp("R3", "mem sel1", int'(sel[3:2]), 2); check_all("R3");
    drive(7, 3, 5, 1, 0, 6, 1, 7, 1);
    cmp("R4", "wb sel0", int'(sel[1:0]), 3); check_all("R4");
    drive(9, 9, 9, 1, 0, 9, 1, 9, 1);
    cmp("R5", "ex over mem/wb", int'(sel), 4'b0101); check_all("R5");
    drive(9, 2, 1, 1, 0, 9, 1, 9, 1);
    cmp("R5", "mem over wb", int'(sel[1:0]), 2); check_all("R5");
    drive(9, 9, 9, 0, 1, 9, 0, 9, 1);
    cmp("R6", "disabled ex/mem", int'(sel), 4'b1111);
    cmp("R6", "disabled ex no stall", int'(hold), 0); check_all("R6");
    drive(0, 0, 0, 1, 1, 0, 1, 0, 1);
    cmp("R7", "r0 sel", int'(sel), 0);
    cmp("R7", "r0 hold", int'(hold), 0); check_all("R7");
    // load-use: load to r8 in execute, consumer reads r8
    drive(8, 2, 8, 1, 1, 8, 1, 2, 1);
    cmp("R8", "hold", int'(hold), 1);
    cmp("R8", "bubble", int'(bubble), 1); check_all("R8");
    // next cycle: bubble in execute, load now in memory
    drive(8, 2, 0, 0, 0, 8, 1, 8, 1);
    cmp("R3", "load from mem", int'(sel[1:0]), 2);
    cmp("R9", "hold released", int'(hold), 0); check_all("R3");
    drive(4, 5, 6, 1, 1, 4, 1, 5, 1);  check_all("R9");
    drive(4, 5, 4, 1, 0, 0, 0, 0, 0);
    cmp("R9", "alu in ex no stall", int'(hold), 0); check_all("R9");
    // one operand bypassed from memory, the other waits on the load
    drive(3, 10, 10, 1, 1, 3, 1, 0, 0);
    cmp("R10", "op0 mem", int'(sel[1:0]), 2);
    cmp("R10", "stall from op1", int'(hold), 1); check_all("R10");
    drive(10, 3, 10, 1, 1, 3, 1, 0, 0);
    cmp("R10", "stall from op0", int'(bubble), 1); check_all("R10");

    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            1'($urandom), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom));
      check_all("R10 rnd");
    end
    finish_run();
  end
endmodule